// File: doc/BRIEF.md
# Multi-mode iterative CORDIC engine

This block is a sequential shift-and-add arithmetic engine. It evaluates elementary functions with the CORDIC recurrence in three coordinate systems: circular, linear and hyperbolic. Each system can run in rotation or in vectoring mode, which gives six operations on one shared datapath. These are sine/cosine and arctangent, multiply and divide, and hyperbolic sine/cosine and inverse hyperbolic tangent. Each cycle performs one micro-rotation, built from two arithmetic right shifts, three add/subtract units and one entry of a small per-step constant table. No multiplier is used.

A caller presents signed fixed-point X, Y and Z operands and a 3-bit operation code, then pulses `start` while the engine is idle. The engine raises `busy` and iterates for a fixed number of cycles that depends only on the coordinate system. It then drops `busy`, pulses `done` for one cycle and holds X, Y and Z results until the next accepted operation. Only one operation is in flight at a time.

Circular and hyperbolic results are not gain-corrected. They carry the product of the per-step stretch factors, which is about 1.6468 for circular and about 0.8282 for hyperbolic at the default step count. The caller pre-scales the operands or divides out the gain.

Top module: `cordic_engine`

## Requirements
- R1: While `rst` is high at a clock edge, the engine goes idle: after that edge `busy` and `done` are 0 and `x_out`, `y_out`, `z_out` are 0.
- R2: `mode[2]` selects vectoring (1) or rotation (0), and `mode[1:0]` selects the coordinate system: 00 circular, 01 linear, 10 hyperbolic. The code 11 in `mode[1:0]` is illegal. A start that carries it is ignored, so `busy` stays 0, no `done` follows and the outputs keep their values.
- R3: A start that is accepted at a clock edge sets `busy` for the following cycle. The circular and linear systems use shift indices 0 to ITERS-1, which gives ITERS steps. The hyperbolic system uses shift indices 1 to ITERS with indices 4 and 13 each taken twice, which gives ITERS+2 steps at the default. `done` is high exactly in the cycle that follows the Nth clock edge after the accepting edge, where N is that step count.
- R4: A start that arrives while `busy` is 1 is ignored. The running operation keeps its latency and its result.
- R5: Circular rotation returns X = K·(x·cos z − y·sin z) and Y = K·(y·cos z + x·sin z), with Z near 0 and K the circular gain. Each output is within 32 LSB.
- R6: Circular vectoring, with x > 0, returns X = K·sqrt(x²+y²), Y near 0 and Z = z + atan(y/x). Each output is within 32 LSB.
- R7: Linear rotation returns X = x, Y = y + x·z and Z near 0, for |z| < 2. Each output is within 32 LSB.
- R8: Linear vectoring, with x > 0 and |y/x| < 2, returns X = x, Y near 0 and Z = z + y/x. Each output is within 32 LSB.
- R9: Hyperbolic rotation returns X = Kh·(x·cosh z + y·sinh z) and Y = Kh·(y·cosh z + x·sinh z), with Z near 0 and Kh the hyperbolic gain, for |z| ≤ 1. Each output is within 32 LSB.
- R10: Hyperbolic vectoring, with x > 0 and |y/x| ≤ 0.75, returns X = Kh·sqrt(x²−y²), Y near 0 and Z = z + atanh(y/x). Each output is within 32 LSB.
- R11: While the engine is idle, `x_out`, `y_out` and `z_out` do not change. They are updated only at the edge that ends an operation.
- R12: `done` is high for exactly one cycle per operation, and `busy` is 0 whenever `done` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a new operation; honoured only while idle and with a legal code |
| mode | input | 3 | Bit 2: vectoring; bits 1:0: coordinate system (00 circular, 01 linear, 10 hyperbolic) |
| x_in | input | W | Signed X operand, FRAC fraction bits |
| y_in | input | W | Signed Y operand, FRAC fraction bits |
| z_in | input | W | Signed Z operand (angle or ratio), FRAC fraction bits |
| busy | output | 1 | High while an operation iterates |
| done | output | 1 | One-cycle pulse when the results are written |
| x_out | output | W | Signed X result |
| y_out | output | W | Signed Y result |
| z_out | output | W | Signed Z result |

## Verification
Most internal faults become visible on the first `done` of an affected operation. A wrong shift sequence, a wrong table entry or a wrong direction decision in one mode leaves that mode's results outside tolerance, while the other five modes stay correct. For this reason each of the six modes gets its own random and directed operand sets. A faulty step counter or hyperbolic repeat schedule shows up as a `done` that arrives one or more cycles early or late. A control fault that lets a start through while busy, or that accepts an illegal code, shows up within a few cycles as a restarted latency, altered results or a `busy` that should have stayed low.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    typedef enum logic [1:0] {
        CRD_CIRC = 2'd0,
        CRD_LIN  = 2'd1,
        CRD_HYP  = 2'd2,
        CRD_BAD  = 2'd3
    } coord_e;

    // mode[2] = vectoring, mode[1:0] = coordinate system
    typedef struct packed {
        logic   vectoring;
        coord_e coord;
    } op_s;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    function automatic logic op_legal(op_s op);
        return op.coord != CRD_BAD;
    endfunction

    // Hyperbolic schedule: shifts 1..iters, with 4 and 13 taken twice.
    function automatic int hyp_steps(int iters);
        int n;
        n = iters;
        if (iters >= 4)  n = n + 1;
        if (iters >= 13) n = n + 1;
        return n;
    endfunction

    function automatic longint pow2_q30(int s);
        if (s > 30) return 64'sd0;
        return longint'(1) << (30 - s);
    endfunction

    // atan(2^-s) scaled by 2^30
    function automatic longint atan_q30(int s);
        case (s)
            0:       return 64'sd843314857;
            1:       return 64'sd497837829;
            2:       return 64'sd263043837;
            3:       return 64'sd133525159;
            4:       return 64'sd67021687;
            5:       return 64'sd33543516;
            6:       return 64'sd16775851;
            7:       return 64'sd8388437;
            8:       return 64'sd4194283;
            9:       return 64'sd2097149;
            default: return pow2_q30(s);
        endcase
    endfunction

    // atanh(2^-s) scaled by 2^30; index 0 is never used
    function automatic longint atanh_q30(int s);
        case (s)
            0:       return 64'sd0;
            1:       return 64'sd589812976;
            2:       return 64'sd274247422;
            3:       return 64'sd134923406;
            4:       return 64'sd67196451;
            5:       return 64'sd33565361;
            6:       return 64'sd16778582;
            7:       return 64'sd8388779;
            8:       return 64'sd4194325;
            9:       return 64'sd2097155;
            default: return pow2_q30(s);
        endcase
    endfunction

    // Rounded conversion from 30 fraction bits to frac fraction bits (frac <= 29)
    function automatic longint q30_to_frac(longint v, int frac);
        return (v + (longint'(1) << (29 - frac))) >>> (30 - frac);
    endfunction

endpackage

// File: rtl/cordic_angle_rom.sv
module cordic_angle_rom
    import cordic_pkg::*;
#(
    parameter int W     = 18,
    parameter int FRAC  = 14,
    parameter int ITERS = 14,
    parameter int SW    = 4
) (
    input  coord_e                coord,
    input  logic [SW-1:0]         shift,
    output logic signed [W-1:0]   step_const
);
    localparam int TAB = ITERS + 1;

    logic signed [W-1:0] circ_tab [TAB];
    logic signed [W-1:0] lin_tab  [TAB];
    logic signed [W-1:0] hyp_tab  [TAB];

    for (genvar g = 0; g < TAB; g++) begin : g_tab
        assign circ_tab[g] = W'(q30_to_frac(atan_q30(g), FRAC));
        assign lin_tab[g]  = W'(q30_to_frac(pow2_q30(g), FRAC));
        assign hyp_tab[g]  = W'(q30_to_frac(atanh_q30(g), FRAC));
    end

    always_comb begin
        case (coord)
            CRD_CIRC: step_const = circ_tab[shift];
            CRD_HYP:  step_const = hyp_tab[shift];
            default:  step_const = lin_tab[shift];
        endcase
    end
endmodule

// File: rtl/cordic_shift_seq.sv
module cordic_shift_seq
    import cordic_pkg::*;
#(
    parameter int ITERS = 14,
    parameter int SW    = 4,
    parameter int CW    = 5
) (
    input  coord_e          coord,
    input  logic [CW-1:0]   step,
    output logic [SW-1:0]   shift,
    output logic            last
);
    localparam int HYP_N = hyp_steps(ITERS);

    int s;
    int total;

    always_comb begin
        if (coord == CRD_HYP) begin
            s = int'(step) + 1;
            if (ITERS >= 4 && int'(step) >= 4)   s = s - 1;
            if (ITERS >= 13 && int'(step) >= 14) s = s - 1;
            total = HYP_N;
        end else begin
            s     = int'(step);
            total = ITERS;
        end
        shift = SW'(s);
        last  = (int'(step) == total - 1);
    end
endmodule

// File: rtl/cordic_microrot.sv
module cordic_microrot
    import cordic_pkg::*;
#(
    parameter int W  = 18,
    parameter int SW = 4
) (
    input  coord_e                coord,
    input  logic                  vectoring,
    input  logic [SW-1:0]         shift,
    input  logic signed [W-1:0]   x,
    input  logic signed [W-1:0]   y,
    input  logic signed [W-1:0]   z,
    input  logic signed [W-1:0]   step_const,
    output logic signed [W-1:0]   nx,
    output logic signed [W-1:0]   ny,
    output logic signed [W-1:0]   nz
);
    logic signed [W-1:0] xs;
    logic signed [W-1:0] ys;
    logic                d_pos;

    assign xs = x >>> shift;
    assign ys = y >>> shift;
    // rotation: follow sign of residual angle; vectoring: oppose sign of y
    assign d_pos = vectoring ? y[W-1] : ~z[W-1];

    always_comb begin
        ny = d_pos ? (y + xs) : (y - xs);
        nz = d_pos ? (z - step_const) : (z + step_const);
        case (coord)
            CRD_CIRC: nx = d_pos ? (x - ys) : (x + ys);
            CRD_HYP:  nx = d_pos ? (x + ys) : (x - ys);
            default:  nx = x;
        endcase
    end
endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
    import cordic_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          accept,
    input  logic          last,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] step
);
    run_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            step  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_RUN;
                        step  <= '0;
                    end
                end
                default: begin
                    if (last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        step <= step + 1'b1;
                    end
                end
            endcase
        end
    end

    assign busy = (state == ST_RUN);
endmodule

// File: rtl/cordic_engine.sv
module cordic_engine
    import cordic_pkg::*;
#(
    parameter int W     = 18,
    parameter int FRAC  = 14,
    parameter int ITERS = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [2:0]          mode,
    input  logic signed [W-1:0] x_in,
    input  logic signed [W-1:0] y_in,
    input  logic signed [W-1:0] z_in,
    output logic                busy,
    output logic                done,
    output logic signed [W-1:0] x_out,
    output logic signed [W-1:0] y_out,
    output logic signed [W-1:0] z_out
);
    localparam int HYP_N = hyp_steps(ITERS);
    localparam int SW    = $clog2(ITERS + 1);
    localparam int CW    = $clog2(HYP_N + 1);

    typedef struct packed {
        logic signed [W-1:0] x;
        logic signed [W-1:0] y;
        logic signed [W-1:0] z;
    } vec_s;

    op_s                 req_op;
    op_s                 cur_op;
    vec_s                work;
    vec_s                nxt;
    vec_s                res;
    logic                accept;
    logic                last;
    logic [CW-1:0]       step;
    logic [SW-1:0]       shift;
    logic signed [W-1:0] step_const;
    logic signed [W-1:0] nx;
    logic signed [W-1:0] ny;
    logic signed [W-1:0] nz;

    assign req_op = op_s'(mode);
    assign accept = start && !busy && op_legal(req_op);

    cordic_ctrl #(.CW(CW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .accept (accept),
        .last   (last),
        .busy   (busy),
        .done   (done),
        .step   (step)
    );

    cordic_shift_seq #(.ITERS(ITERS), .SW(SW), .CW(CW)) u_seq (
        .coord (cur_op.coord),
        .step  (step),
        .shift (shift),
        .last  (last)
    );

    cordic_angle_rom #(.W(W), .FRAC(FRAC), .ITERS(ITERS), .SW(SW)) u_rom (
        .coord      (cur_op.coord),
        .shift      (shift),
        .step_const (step_const)
    );

    cordic_microrot #(.W(W), .SW(SW)) u_rot (
        .coord      (cur_op.coord),
        .vectoring  (cur_op.vectoring),
        .shift      (shift),
        .x          (work.x),
        .y          (work.y),
        .z          (work.z),
        .step_const (step_const),
        .nx         (nx),
        .ny         (ny),
        .nz         (nz)
    );

    assign nxt = '{x: nx, y: ny, z: nz};

    always_ff @(posedge clk) begin
        if (rst) begin
            work   <= '0;
            res    <= '0;
            cur_op <= '{vectoring: 1'b0, coord: CRD_CIRC};
        end else if (accept) begin
            work   <= '{x: x_in, y: y_in, z: z_in};
            cur_op <= req_op;
        end else if (busy) begin
            work <= nxt;
            if (last) res <= nxt;
        end
    end

    assign x_out = res.x;
    assign y_out = res.y;
    assign z_out = res.z;
endmodule

// File: rtl/cordic_engine_chk.sv
module cordic_engine_chk
    import cordic_pkg::*;
#(
    parameter int W     = 18,
    parameter int ITERS = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic [2:0]          mode,
    input logic                busy,
    input logic                done,
    input logic signed [W-1:0] x_out,
    input logic signed [W-1:0] y_out,
    input logic signed [W-1:0] z_out
);
    localparam int HYP_N = hyp_steps(ITERS);

    op_s m_op;
    logic acc;
    int cnt;
    int need;

    assign m_op = op_s'(mode);
    assign acc  = start && !busy && op_legal(m_op);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= 0;
            need <= 0;
        end else if (acc) begin
            cnt  <= 0;
            need <= (m_op.coord == CRD_HYP) ? HYP_N : ITERS;
        end else if (busy) begin
            cnt <= cnt + 1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && x_out == 0 && y_out == 0 && z_out == 0));

    assert_illegal_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && !op_legal(m_op)) |=> !busy);

    assert_accept_busy_R3: assert property (@(posedge clk) disable iff (rst)
        acc |=> busy);

    assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (cnt == need));

    assert_busy_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt < need - 1) |=> busy);

    assert_hold_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(x_out) && $stable(y_out) && $stable(z_out)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);
endmodule

bind cordic_engine cordic_engine_chk #(.W(W), .ITERS(ITERS)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (start),
    .mode  (mode),
    .busy  (busy),
    .done  (done),
    .x_out (x_out),
    .y_out (y_out),
    .z_out (z_out)
);

// File: tb/cordic_engine_bench.sv
module cordic_engine_bench;
    localparam int  W     = 18;
    localparam int  FRAC  = 14;
    localparam int  ITERS = 14;
    localparam int  TOL   = 32;
    localparam int  N_CL  = ITERS;
    localparam int  N_HYP = ITERS + 2;
    localparam real SC    = 2.0 ** FRAC;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                start = 1'b0;
    logic [2:0]          mode = 3'b000;
    logic signed [W-1:0] x_in = '0;
    logic signed [W-1:0] y_in = '0;
    logic signed [W-1:0] z_in = '0;
    logic                busy;
    logic                done;
    logic signed [W-1:0] x_out;
    logic signed [W-1:0] y_out;
    logic signed [W-1:0] z_out;

    int  checks = 0;
    int  errors = 0;
    real kc;
    real kh;

    always #10 clk = ~clk;

    cordic_engine #(.W(W), .FRAC(FRAC), .ITERS(ITERS)) u_cordic_engine (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .x_in(x_in), .y_in(y_in), .z_in(z_in),
        .busy(busy), .done(done),
        .x_out(x_out), .y_out(y_out), .z_out(z_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int fx(input real r);
        if (r >= 0.0) return $rtoi(r * SC + 0.5);
        return -$rtoi(-r * SC + 0.5);
    endfunction

    function automatic real rnd(input real lo, input real hi);
        return lo + (hi - lo) * real'($urandom % 10001) / 10000.0;
    endfunction

    task automatic near(input string req, input string what,
                        input logic signed [W-1:0] act, input real exp);
        int e;
        int a;
        e = fx(exp);
        a = int'(act);
        chk((a - e) <= TOL && (e - a) <= TOL, req, what, a, e);
    endtask

    // Runs one operation; poke >= 0 injects a start with other data that many cycles in.
    task automatic run_op(input logic [2:0] m, input real xr, input real yr,
                          input real zr, input int poke);
        int  lat;
        int  nexp;
        real x, y, z, ex, ey, ez;
        string req;
        logic signed [W-1:0] hx, hy, hz;
        @(negedge clk);
        mode  = m;
        x_in  = W'(fx(xr));
        y_in  = W'(fx(yr));
        z_in  = W'(fx(zr));
        start = 1'b1;
        x = real'(fx(xr)) / SC;
        y = real'(fx(yr)) / SC;
        z = real'(fx(zr)) / SC;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R3", "busy after accept", int'(busy), 1);
        lat = 0;
        while (!done && lat < 200) begin
            if (lat == poke) begin
                start = 1'b1;
                mode  = 3'b001;
                x_in  = W'(fx(0.3));
                y_in  = W'(fx(-0.2));
                z_in  = W'(fx(0.7));
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        nexp = (m[1:0] == 2'b10) ? N_HYP : N_CL;
        chk(lat == nexp, (poke >= 0) ? "R4" : "R3", "latency", lat, nexp);
        chk(busy == 1'b0, "R12", "busy low with done", int'(busy), 0);
        case (m)
            3'b000: begin req = "R5";  ex = kc * (x * $cos(z) - y * $sin(z));
                          ey = kc * (y * $cos(z) + x * $sin(z)); ez = 0.0; end
            3'b100: begin req = "R6";  ex = kc * $sqrt(x * x + y * y); ey = 0.0;
                          ez = z + $atan(y / x); end
            3'b001: begin req = "R7";  ex = x; ey = y + x * z; ez = 0.0; end
            3'b101: begin req = "R8";  ex = x; ey = 0.0; ez = z + y / x; end
            3'b010: begin req = "R9";  ex = kh * (x * $cosh(z) + y * $sinh(z));
                          ey = kh * (y * $cosh(z) + x * $sinh(z)); ez = 0.0; end
            default: begin req = "R10"; ex = kh * $sqrt(x * x - y * y); ey = 0.0;
                          ez = z + $atanh(y / x); end
        endcase
        if (poke >= 0) req = "R4";
        near(req, "x_out", x_out, ex);
        near(req, "y_out", y_out, ey);
        near(req, "z_out", z_out, ez);
        hx = x_out; hy = y_out; hz = z_out;
        @(negedge clk);
        chk(done == 1'b0, "R12", "done one cycle", int'(done), 0);
        repeat (2) @(negedge clk);
        chk(x_out == hx && y_out == hy && z_out == hz, "R11", "x_out held",
            int'(x_out), int'(hx));
    endtask

    task automatic try_illegal(input logic [2:0] m);
        logic signed [W-1:0] hx, hy, hz;
        bit seen;
        hx = x_out; hy = y_out; hz = z_out;
        @(negedge clk);
        mode = m; x_in = W'(fx(0.5)); y_in = W'(fx(0.25)); z_in = W'(fx(0.1));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b0, "R2", "busy after illegal code", int'(busy), 0);
        seen = 1'b0;
        for (int i = 0; i < N_HYP + 3; i++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
        end
        chk(!seen, "R2", "activity after illegal code", int'(seen), 0);
        chk(x_out == hx && y_out == hy && z_out == hz, "R2", "outputs kept",
            int'(x_out), int'(hx));
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        kc = 1.0;
        for (int i = 0; i < ITERS; i++) kc = kc * $sqrt(1.0 + 2.0 ** (-2 * i));
        kh = 1.0;
        for (int s = 1; s <= ITERS; s++) begin
            kh = kh * $sqrt(1.0 - 2.0 ** (-2 * s));
            if (s == 4 || s == 13) kh = kh * $sqrt(1.0 - 2.0 ** (-2 * s));
        end

        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R1", "busy/done in reset",
            int'({busy, done}), 0);
        chk(x_out == 0 && y_out == 0 && z_out == 0, "R1", "outputs in reset",
            int'(x_out), 0);
        rst = 1'b0;

        // directed corners
        run_op(3'b000, 0.5, 0.0, 0.0, -1);
        run_op(3'b000, 0.6, 0.0, 1.5, -1);
        run_op(3'b100, 0.7, 0.0, 0.0, -1);
        run_op(3'b100, 0.2, -0.9, 0.0, -1);
        run_op(3'b001, -0.9, 0.0, -1.8, -1);
        run_op(3'b101, 0.5, -0.9, 0.0, -1);
        run_op(3'b010, 0.5, 0.0, 1.0, -1);
        run_op(3'b110, 0.8, 0.6, 0.0, -1);
        try_illegal(3'b011);
        try_illegal(3'b111);
        run_op(3'b000, 0.4, 0.3, 0.9, 3);
        run_op(3'b010, 0.4, -0.2, -0.8, N_HYP - 2);

        // random operands per mode
        for (int k = 0; k < 12; k++) begin
            real xa;
            run_op(3'b000, rnd(-0.6, 0.6), rnd(-0.6, 0.6), rnd(-1.5, 1.5), -1);
            run_op(3'b100, rnd(0.2, 0.9), rnd(-0.9, 0.9), rnd(-0.3, 0.3), -1);
            run_op(3'b001, rnd(-0.9, 0.9), rnd(-0.9, 0.9), rnd(-1.8, 1.8), -1);
            run_op(3'b101, rnd(0.5, 0.9), rnd(-0.9, 0.9), rnd(-0.05, 0.05), -1);
            run_op(3'b010, rnd(0.2, 0.6), rnd(-0.3, 0.3), rnd(-1.0, 1.0), -1);
            xa = rnd(0.5, 0.9);
            run_op(3'b110, xa, xa * rnd(-0.75, 0.75), rnd(-0.2, 0.2), -1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule